// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Pin-Compressed Test Mode

This block models the device side of an asynchronous multiplexed-address DRAM at the strobe level. A fast internal clock samples the row strobe, column strobe and write-enable pins. Each sampled falling edge of the row strobe is sorted into one of four cases: a normal access, a row-only refresh, a column-before-row refresh, or a test-mode entry. The block keeps the internal refresh row counter and the test-mode flag. It holds a small storage array whose size is set by parameters, and it drives the data pins with a separate output-enable signal that stands in for a three-state buffer.

In test mode the array is seen as half as many words of twice the width. Every data pin owns a pair of internal bits: the two columns that differ only in the column LSB. A write copies the pin value into both bits. A read returns, for each pin, whether its two bits agree. A controller testbench can use the block as a self-checking target. Refresh ordering, test-mode entry and exit, output gating and the self-refresh timer are all visible at its ports.

Top module: `dram_strobe_decoder`

## Requirements
- R1: When the column strobe is already low at the sampled row-strobe fall, the cycle is a refresh from the internal counter. The address pins are ignored, no stored data changes, and `refresh_row` rises by one on the next clock, wrapping from 1023 to 0 (REF_W = 10).
- R2: When the column strobe stays high for the whole row-strobe low period, the cycle is a row-only refresh. `dq_en` stays 0, stored data is unchanged, and test mode is cleared when the row strobe rises.
- R3: A counter refresh with `we_n` low at the row-strobe fall sets `test_mode` to 1. The cycle also advances `refresh_row`.
- R4: A counter refresh with `we_n` high at the row-strobe fall sets `test_mode` to 0.
- R5: In a normal access, the row is taken from the address at the row-strobe fall and the column from the address at each column-strobe fall. With `we_n` low, `din` is stored. With `we_n` high, the stored word is read. Several column-strobe pulses inside one row-strobe low period each access their own column.
- R6: A test-mode write ignores the column LSB and writes `din` into both columns of the pair (LSB 0 and LSB 1).
- R7: A test-mode read drives pin i to 1 when bit i of the two paired columns is equal and to 0 when it differs, separately for each pin.
- R8: `dq_en` is 1 only after a read's column-strobe fall has been sampled, while `cas_n` and `oe_n` are both low. It drops in the same cycle that either pin goes high, and `dq_out` is 0 while `dq_en` is 0. A counter refresh with the column strobe held low keeps the read data driven.
- R9: A write (`we_n` low at the column-strobe fall) keeps `dq_en` at 0 for that column cycle, even with `oe_n` low.
- R10: After a counter refresh, if both strobes stay low for SREF_ENTRY clocks, `self_ref` becomes 1. The counter then advances once every SREF_TICK clocks, and `self_ref` clears when the row strobe rises.
- R11: `proto_err` pulses for one clock when the column strobe rises while the row strobe is high, having fallen while the row strobe was high with no row-strobe fall in between.
- R12: After reset, `test_mode`, `self_ref`, `proto_err`, `dq_en`, `dq_out` and `refresh_row` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DQ_W | Write data from the pins |
| dq_out | output | DQ_W | Read data, 0 when not driven |
| dq_en | output | 1 | Data pins driven (low impedance) |
| test_mode | output | 1 | Pin-compressed test mode active |
| self_ref | output | 1 | Self refresh active |
| refresh_row | output | REF_W | Internal refresh row counter |
| proto_err | output | 1 | One-clock pulse on an orphan column-strobe pulse |

## Verification
A misclassified row-strobe edge shows up one clock later, either as a `refresh_row` that failed to step or as a `test_mode` flag with the wrong value. A wrong pairing of test columns cannot be seen at once. It appears only at the next read: a compare result in test mode, or the word returned after exit. A stale valid flag shows as `dq_en` staying high after the column strobe rises. A late self-refresh entry shifts the counter value seen after a fixed hold.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_ACCESS = 2'd1,
    CYC_CBR    = 2'd2,
    CYC_SELF   = 2'd3
  } cyc_t;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= pin_n[i];
    end
    assign fall[i] = prev_q[i] & ~pin_n[i];
    assign rise[i] = ~prev_q[i] & pin_n[i];
  end
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_dec_pkg::*;
#(
  parameter int ROW_BITS   = 2,
  parameter int REF_W      = 10,
  parameter int SREF_ENTRY = 12500,
  parameter int SREF_TICK  = 1000,
  localparam int SW = $clog2(SREF_ENTRY),
  localparam int TW = $clog2(SREF_TICK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                ras_fall,
  input  logic                ras_rise,
  input  logic                cas_fall,
  input  logic                cas_rise,
  input  logic [ROW_BITS-1:0] row_in,
  output logic [ROW_BITS-1:0] row_q,
  output logic                acc_strobe,
  output logic                test_mode,
  output logic                self_ref,
  output logic                proto_err,
  output logic [REF_W-1:0]    refresh_row
);
  cyc_t                state_q, state_d;
  logic                test_q, test_d;
  logic [REF_W-1:0]    ref_q, ref_d;
  logic [ROW_BITS-1:0] row_d;
  logic                seen_q, seen_d;
  logic [SW-1:0]       sref_q, sref_d;
  logic [TW-1:0]       tick_q, tick_d;
  logic                pre_q, pre_d;
  logic                err_q, err_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    test_d  = test_q;
    ref_d   = ref_q;
    row_d   = row_q;
    seen_d  = seen_q;
    sref_d  = sref_q;
    tick_d  = tick_q;
    pre_d   = pre_q;
    err_d   = 1'b0;

    unique case (state_q)
      CYC_IDLE: begin
        if (ras_fall) begin
          if (!cas_n) begin
            state_d = CYC_CBR;          // counter refresh, address ignored
            ref_d   = ref_q + 1'b1;
            test_d  = ~we_n;            // W low enters, W high leaves
            sref_d  = '0;
          end else begin
            state_d = CYC_ACCESS;
            row_d   = row_in;
            seen_d  = 1'b0;
          end
        end
      end
      CYC_ACCESS: begin
        if (cas_fall) seen_d = 1'b1;
        if (ras_rise) begin
          state_d = CYC_IDLE;
          if (!seen_q && !cas_fall) test_d = 1'b0;  // row-only refresh
        end
      end
      CYC_CBR: begin
        if (ras_rise) begin
          state_d = CYC_IDLE;
        end else if (cas_n) begin
          sref_d = '0;
        end else if (sref_q == SW'(SREF_ENTRY - 1)) begin
          state_d = CYC_SELF;
          tick_d  = '0;
        end else begin
          sref_d = sref_q + 1'b1;
        end
      end
      CYC_SELF: begin
        if (ras_rise) begin
          state_d = CYC_IDLE;
        end else if (tick_q == TW'(SREF_TICK - 1)) begin
          tick_d = '0;
          ref_d  = ref_q + 1'b1;
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      default: state_d = CYC_IDLE;
    endcase

    // orphan column-strobe pulse tracking
    if (cas_fall && ras_n) pre_d = 1'b1;
    if (ras_fall)          pre_d = 1'b0;
    if (cas_rise && ras_n && pre_q) begin
      err_d = 1'b1;
      pre_d = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      test_q  <= 1'b0;
      ref_q   <= '0;
      row_q   <= '0;
      seen_q  <= 1'b0;
      sref_q  <= '0;
      tick_q  <= '0;
      pre_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      test_q  <= test_d;
      ref_q   <= ref_d;
      row_q   <= row_d;
      seen_q  <= seen_d;
      sref_q  <= sref_d;
      tick_q  <= tick_d;
      pre_q   <= pre_d;
      err_q   <= err_d;
    end
  end

  assign acc_strobe  = (state_q == CYC_ACCESS) & cas_fall;
  assign test_mode   = test_q;
  assign self_ref    = (state_q == CYC_SELF);
  assign proto_err   = err_q;
  assign refresh_row = ref_q;
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int DQ_W     = 4,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 3,
  localparam int IW    = ROW_BITS + COL_BITS,
  localparam int DEPTH = 1 << IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_strobe,
  input  logic                cas_rise,
  input  logic                we_n,
  input  logic                test_mode,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic [DQ_W-1:0]     din,
  output logic [DQ_W-1:0]     rd_data,
  output logic                rd_valid
);
  logic [DQ_W-1:0] mem [DEPTH];
  logic [IW-1:0]   idx_n, idx_e, idx_o;
  logic [DQ_W-1:0] word_e, word_o, cmp, rd_d;
  logic            wr_en, rd_en;

  assign idx_n  = {row, col};
  assign idx_e  = {row, col[COL_BITS-1:1], 1'b0};
  assign idx_o  = {row, col[COL_BITS-1:1], 1'b1};
  assign word_e = mem[idx_e];
  assign word_o = mem[idx_o];

  for (genvar p = 0; p < DQ_W; p++) begin : g_cmp
    assign cmp[p] = (word_e[p] == word_o[p]);
  end

  assign wr_en = acc_strobe & ~we_n;
  assign rd_en = acc_strobe & we_n;
  assign rd_d  = test_mode ? cmp : mem[idx_n];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (test_mode) begin
        mem[idx_e] <= din;
        mem[idx_o] <= din;
      end else begin
        mem[idx_n] <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_d;
      if (acc_strobe)    rd_valid <= we_n;
      else if (cas_rise) rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder #(
  parameter int DQ_W       = 4,
  parameter int ROW_BITS   = 2,
  parameter int COL_BITS   = 3,
  parameter int REF_W      = 10,
  parameter int SREF_ENTRY = 12500,
  parameter int SREF_TICK  = 1000,
  localparam int ADDR_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_en,
  output logic              test_mode,
  output logic              self_ref,
  output logic [REF_W-1:0]  refresh_row,
  output logic              proto_err
);
  logic [1:0]          rst_sync;
  logic                rst_q;
  logic [1:0]          fall, rise;
  logic                ras_fall, ras_rise, cas_fall, cas_rise;
  logic [ROW_BITS-1:0] row_q;
  logic                acc_strobe, rd_valid;
  logic [DQ_W-1:0]     rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  strobe_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_q),
    .pin_n ({cas_n, ras_n}),
    .fall  (fall),
    .rise  (rise)
  );
  assign ras_fall = fall[0];
  assign cas_fall = fall[1];
  assign ras_rise = rise[0];
  assign cas_rise = rise[1];

  dram_cycle_fsm #(
    .ROW_BITS   (ROW_BITS),
    .REF_W      (REF_W),
    .SREF_ENTRY (SREF_ENTRY),
    .SREF_TICK  (SREF_TICK)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_q),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ras_fall    (ras_fall),
    .ras_rise    (ras_rise),
    .cas_fall    (cas_fall),
    .cas_rise    (cas_rise),
    .row_in      (addr[ROW_BITS-1:0]),
    .row_q       (row_q),
    .acc_strobe  (acc_strobe),
    .test_mode   (test_mode),
    .self_ref    (self_ref),
    .proto_err   (proto_err),
    .refresh_row (refresh_row)
  );

  dram_cell_array #(
    .DQ_W     (DQ_W),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_q),
    .acc_strobe (acc_strobe),
    .cas_rise   (cas_rise),
    .we_n       (we_n),
    .test_mode  (test_mode),
    .row        (row_q),
    .col        (addr[COL_BITS-1:0]),
    .din        (din),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  assign dq_en  = rd_valid & ~cas_n & ~oe_n;
  assign dq_out = dq_en ? rd_data : '0;
endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk #(
  parameter int REF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             ras_fall,
  input logic             cas_fall,
  input logic             dq_en,
  input logic             test_mode,
  input logic             self_ref,
  input logic             proto_err,
  input logic [REF_W-1:0] refresh_row
);
  a_r1_cbr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n) |=> (refresh_row == REF_W'($past(refresh_row) + 1'b1)));

  a_r3_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> test_mode);

  a_r4_test_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);

  a_r8_drive_needs_pins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_en) |-> (!cas_n && !oe_n));

  a_r9_early_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !ras_n && !we_n) |=> !dq_en);

  a_r10_self_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_ref) |-> (!ras_n && !cas_n));

  a_r11_err_context: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(ras_n) && $past(cas_n)));
endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.REF_W(REF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .oe_n        (oe_n),
  .ras_fall    (ras_fall),
  .cas_fall    (cas_fall),
  .dq_en       (dq_en),
  .test_mode   (test_mode),
  .self_ref    (self_ref),
  .proto_err   (proto_err),
  .refresh_row (refresh_row)
);

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;
  localparam int DW = 4, RB = 2, CB = 3, AW = 3, RW = 10, SE = 32, ST = 8;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CT = 3'd2, OP_CN = 3'd3,
                         OP_RO = 3'd4, OP_TW = 3'd5, OP_TR = 3'd6;
  localparam int NV = 24;
  // {op, row, col, data-or-expected}
  localparam logic [11:0] VECS [NV] = '{
    {OP_WR, 2'd1, 3'd2, 4'hA}, {OP_WR, 2'd1, 3'd3, 4'h5},
    {OP_RD, 2'd1, 3'd2, 4'hA}, {OP_RD, 2'd1, 3'd3, 4'h5},
    {OP_WR, 2'd2, 3'd0, 4'hF}, {OP_RD, 2'd2, 3'd0, 4'hF},
    {OP_WR, 2'd3, 3'd0, 4'h3}, {OP_WR, 2'd3, 3'd1, 4'h6},
    {OP_CT, 2'd0, 3'd0, 4'h1}, {OP_TR, 2'd1, 3'd2, 4'h0},
    {OP_TR, 2'd3, 3'd1, 4'hA}, {OP_TW, 2'd2, 3'd4, 4'h6},
    {OP_TR, 2'd2, 3'd5, 4'hF}, {OP_TW, 2'd1, 3'd3, 4'h9},
    {OP_TR, 2'd1, 3'd2, 4'hF}, {OP_CN, 2'd0, 3'd0, 4'h0},
    {OP_RD, 2'd2, 3'd4, 4'h6}, {OP_RD, 2'd2, 3'd5, 4'h6},
    {OP_RD, 2'd1, 3'd2, 4'h9}, {OP_RD, 2'd1, 3'd3, 4'h9},
    {OP_CT, 2'd3, 3'd7, 4'h1}, {OP_RO, 2'd0, 3'd0, 4'h0},
    {OP_RD, 2'd2, 3'd0, 4'hF}, {OP_RD, 2'd3, 3'd0, 4'h3}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ras_n, cas_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dq_out;
  logic dq_en, test_mode, self_ref, proto_err;
  logic [RW-1:0] refresh_row;
  int errs = 0, checks = 0, exp_ref = 0;
  bit done = 0;

  dram_strobe_decoder #(.DQ_W(DW), .ROW_BITS(RB), .COL_BITS(CB), .REF_W(RW),
                        .SREF_ENTRY(SE), .SREF_TICK(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_en(dq_en),
    .test_mode(test_mode), .self_ref(self_ref), .refresh_row(refresh_row),
    .proto_err(proto_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_write(input int row, input int col, input logic [DW-1:0] d, input string req);
    @(negedge clk) addr = AW'(row); ras_n = 0;
    @(negedge clk) addr = AW'(col); we_n = 0; din = d; oe_n = 0;
    @(negedge clk) cas_n = 0;
    @(negedge clk) chk({req, " / R9 write keeps pins off"}, 32'(dq_en), 0);
    cas_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk) ras_n = 1;
    @(negedge clk);
  endtask

  task automatic t_read(input int row, input int col, input logic [DW-1:0] e, input string req);
    @(negedge clk) addr = AW'(row); ras_n = 0;
    @(negedge clk) addr = AW'(col); oe_n = 0;
    @(negedge clk) cas_n = 0;
    @(negedge clk) chk({req, " dq_en"}, 32'(dq_en), 1);
    chk({req, " data"}, 32'(dq_out), 32'(e));
    cas_n = 1;
    @(negedge clk) chk("R8 off after column strobe rise", 32'(dq_en), 0);
    ras_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic t_cbr(input logic w);
    @(negedge clk) cas_n = 0;
    @(negedge clk) ras_n = 0; we_n = w;
    @(negedge clk) ras_n = 1;
    @(negedge clk) cas_n = 1; we_n = 1;
    @(negedge clk);
    exp_ref++;
  endtask

  task automatic t_ror(input int row);
    @(negedge clk) addr = AW'(row); ras_n = 0; oe_n = 0;
    @(negedge clk);
    @(negedge clk) chk("R2 row-only refresh pins off", 32'(dq_en), 0);
    ras_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R12 test_mode", 32'(test_mode), 0);
    chk("R12 refresh_row", 32'(refresh_row), 0);
    chk("R12 dq_en", 32'(dq_en), 0);
    chk("R12 dq_out", 32'(dq_out), 0);
    chk("R12 self_ref", 32'(self_ref), 0);
    chk("R12 proto_err", 32'(proto_err), 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      int r, c;
      logic [3:0] d;
      op = VECS[i][11:9]; r = int'(VECS[i][8:7]); c = int'(VECS[i][6:4]); d = VECS[i][3:0];
      case (op)
        OP_WR: t_write(r, c, d, "R5 write");
        OP_TW: t_write(r, c, d, "R6 test write");
        OP_RD: t_read(r, c, d, "R5 read");
        OP_TR: t_read(r, c, d, "R7 test compare");
        OP_CT, OP_CN: begin
          t_cbr(op == OP_CT ? 1'b0 : 1'b1);
          chk(op == OP_CT ? "R3 test entry" : "R4 test exit", 32'(test_mode), 32'(d[0]));
          chk("R1 counter step", 32'(refresh_row), 32'(exp_ref % 1024));
        end
        OP_RO: begin
          t_ror(r);
          chk("R2 row-only leaves test mode", 32'(test_mode), 0);
          chk("R2 counter untouched", 32'(refresh_row), 32'(exp_ref % 1024));
        end
        default: ;
      endcase
    end

    // R8: OE gating, page mode and hidden refresh
    @(negedge clk) addr = 3'd2; ras_n = 0;
    @(negedge clk) addr = 3'd0; oe_n = 1;
    @(negedge clk) cas_n = 0;
    @(negedge clk) chk("R8 OE high keeps pins off", 32'(dq_en), 0);
    chk("R8 dq_out zero when off", 32'(dq_out), 0);
    oe_n = 0;
    @(negedge clk) chk("R8 OE low drives", 32'(dq_en), 1);
    chk("R8 data", 32'(dq_out), 32'hF);
    oe_n = 1;
    @(negedge clk) chk("R8 OE rise releases", 32'(dq_en), 0);
    oe_n = 0; cas_n = 1; addr = 3'd4;
    @(negedge clk) cas_n = 0;
    @(negedge clk) chk("R5 page second column", 32'(dq_out), 32'h6);
    ras_n = 1;
    @(negedge clk) ras_n = 0;
    @(negedge clk) exp_ref++;
    chk("R8 hidden refresh keeps driving", 32'(dq_en), 1);
    chk("R8 hidden refresh data", 32'(dq_out), 32'h6);
    chk("R1 hidden refresh step", 32'(refresh_row), 32'(exp_ref % 1024));
    ras_n = 1;
    @(negedge clk) cas_n = 1; oe_n = 1;
    @(negedge clk) chk("R8 released", 32'(dq_en), 0);
    chk("R11 no error on hidden refresh", 32'(proto_err), 0);

    // R11: orphan column-strobe pulse
    @(negedge clk) cas_n = 0;
    @(negedge clk) cas_n = 1;
    @(negedge clk) chk("R11 error pulse", 32'(proto_err), 1);
    @(negedge clk) chk("R11 pulse one clock", 32'(proto_err), 0);

    // R10: self refresh
    @(negedge clk) cas_n = 0;
    @(negedge clk) ras_n = 0;
    exp_ref++;
    repeat (SE + 4 * ST + 4) @(negedge clk);
    chk("R10 self refresh active", 32'(self_ref), 1);
    exp_ref += 4;
    chk("R10 timer advances counter", 32'(refresh_row), 32'(exp_ref % 1024));
    ras_n = 1; cas_n = 1;
    @(negedge clk) chk("R10 exit on row strobe rise", 32'(self_ref), 0);
    chk("R11 no error after self refresh", 32'(proto_err), 0);

    // R1: wrap at 1024
    begin
      int n;
      n = 1024 - (exp_ref % 1024);
      for (int k = 0; k < n; k++) t_cbr(1'b1);
    end
    chk("R1 counter wraps to 0", 32'(refresh_row), 0);
    t_read(2, 0, 4'hF, "R1 refresh left data intact");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule